// File: doc/BRIEF.md
# Bulk Command Wrapper Configuration Decoder

This block watches a mass-storage bulk-out command wrapper as it arrives one byte per accepted beat (`in_valid`, with `in_last` on the final byte). It decides whether the wrapper carries a vendor configuration-access command. It pulls out the transfer length and the transfer direction. It reports the outcome as one pulse of `dec_valid` in the cycle after the last byte. The byte that identifies the vendor command comes from the `vendor_code` input, so software-held configuration can set it without touching the logic.

A small state machine in `cbw_frame_fsm` counts the bytes and recognises the frame boundaries. Its states are:

- `ST_IDLE`: waiting for byte 0.
- `ST_COLLECT`: bytes 1 to 30 are arriving.
- `ST_OVERRUN`: the 31st byte came without `in_last`, and the remaining bytes are discarded up to `in_last`.

Its transitions are:

- IDLE→COLLECT: a first byte arrives without last.
- IDLE→IDLE: a first byte arrives with last, which reports a short frame.
- COLLECT→IDLE: any byte arrives with last.
- COLLECT→OVERRUN: byte 30 arrives without last.
- OVERRUN→IDLE: a byte arrives with last.

While bytes arrive, a per-byte checker compares each one against the field that its position selects, and an accumulator gathers the resulting flags. A following stage then moves the verdict into the output registers.

Top module: `cbw_cfg_decoder`

## Requirements
- R1: After reset, and after a reset that lands in the middle of a frame, `dec_valid`, `dec_is_cfg`, `dec_dir`, `dec_err` are 0 and `dec_len` is 0; the next full frame decodes normally.
- R2: `dec_valid` is high for exactly the cycle after the clock edge that accepts a byte with `in_last`; the other outputs change only at that edge and hold their value otherwise.
- R3: `dec_len` is bytes 8..11 read little-endian (byte 8 is bits 7:0); `dec_dir` is bit 7 of byte 12, where 1 means device-to-host (read) and 0 means host-to-device (load).
- R4: `dec_is_cfg` is 1 exactly when byte 15 equals `vendor_code` and byte 16 equals 0x26.
- R5: Bytes 0..3 must be 0x55, 0x53, 0x42, 0x43 (the value 0x43425355 little-endian); any mismatch sets `dec_err`, whether or not the frame is a config command.
- R6: A frame whose `in_last` falls on any byte other than the 31st (index 30), whether shorter or longer, sets `dec_err`.
- R7: For a config command, byte 18 must be 0x02, and bytes 17 and 19..30 must be 0x00; any mismatch gives `dec_is_cfg`=1 with `dec_err`=1.
- R8: For a config command, a length above 255 sets `dec_err`; 255 itself is accepted.
- R9: For a frame that is not a config command, the contents of bytes 17..30 and the length limit have no effect: a correctly framed wrapper with a good signature reports `dec_err`=0.
- R10: Bytes count only on cycles with `in_valid` high, so idle gaps inside a frame change nothing, and a new frame may start in the cycle right after the previous last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` this cycle |
| in_data | input | 8 | Wrapper byte |
| in_last | input | 1 | Marks the final byte of a wrapper |
| vendor_code | input | 8 | Expected value of command byte 0 (wrapper byte 15) |
| dec_valid | output | 1 | One-cycle pulse: decode result is fresh |
| dec_is_cfg | output | 1 | Designator and 0x26 marker matched |
| dec_dir | output | 1 | 1 = read (device to host), 0 = load |
| dec_len | output | 32 | Transfer length from bytes 8..11 |
| dec_err | output | 1 | Framing, signature or config-field error |

## Verification
The hardest case to reach is a frame that runs past 31 bytes. The machine has to go through `ST_OVERRUN`, drop the extra bytes without damaging the fields it has already captured, and then report at the late `in_last`. The table drives 33-byte frames for this, alongside frames cut short in the middle of the command block. Directed tests cover three further cases: a new wrapper whose first byte arrives in the same cycle as the previous report, a reset in the middle of a frame, and a one-byte frame that finishes while the machine is still in `ST_IDLE`.

// File: rtl/cbw_cfg_pkg.sv
package cbw_cfg_pkg;

    // Wrapper byte positions the decoder relies on
    localparam int CBW_SIG_BASE = 0;
    localparam int CBW_LEN_BASE = 8;
    localparam int CBW_FLAG_IDX = 12;

    // Offsets inside the command block
    localparam int CB_MARK_OFF = 1;
    localparam int CB_MSEL_OFF = 3;
    localparam int CB_RSV_FROM = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_OVERRUN
    } frame_st_e;

    typedef struct packed {
        logic        sig_bad;
        logic        des_hit;
        logic        mark_hit;
        logic        rsv_bad;
        logic        dir;
        logic [31:0] len;
    } cbw_acc_t;

endpackage

// File: rtl/cbw_frame_fsm.sv
module cbw_frame_fsm
    import cbw_cfg_pkg::*;
#(
    parameter int CBW_BYTES = 31,
    parameter int IW        = $clog2(CBW_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    output logic [IW-1:0] byte_idx,
    output logic          first,
    output logic          capture,
    output logic          fin,
    output logic          fin_len_err
);

    localparam logic [IW-1:0] LAST_IDX = IW'(CBW_BYTES - 1);

    frame_st_e     st_q, st_n;
    logic [IW-1:0] idx_q, idx_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_n;
            idx_q <= idx_n;
        end
    end

    // next state and strobes
    always_comb begin
        st_n        = st_q;
        idx_n       = idx_q;
        first       = 1'b0;
        capture     = 1'b0;
        fin         = 1'b0;
        fin_len_err = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) begin
                    first   = 1'b1;
                    capture = 1'b1;
                    if (in_last) begin
                        fin         = 1'b1;
                        fin_len_err = 1'b1;
                    end else begin
                        st_n  = ST_COLLECT;
                        idx_n = IW'(1);
                    end
                end
            end
            ST_COLLECT: begin
                if (in_valid) begin
                    capture = 1'b1;
                    if (in_last) begin
                        fin         = 1'b1;
                        fin_len_err = (idx_q != LAST_IDX);
                        st_n        = ST_IDLE;
                        idx_n       = '0;
                    end else if (idx_q == LAST_IDX) begin
                        st_n  = ST_OVERRUN;
                        idx_n = '0;
                    end else begin
                        idx_n = idx_q + IW'(1);
                    end
                end
            end
            ST_OVERRUN: begin
                if (in_valid && in_last) begin
                    fin         = 1'b1;
                    fin_len_err = 1'b1;
                    st_n        = ST_IDLE;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                idx_n = '0;
            end
        endcase
    end

    assign byte_idx = idx_q;

endmodule

// File: rtl/cbw_byte_check.sv
module cbw_byte_check
    import cbw_cfg_pkg::*;
#(
    parameter int          CBW_BYTES = 31,
    parameter int          CB_OFFSET = 15,
    parameter int          IW        = $clog2(CBW_BYTES),
    parameter logic [31:0] SIGNATURE = 32'h4342_5355,
    parameter logic [7:0]  MARKER    = 8'h26,
    parameter logic [7:0]  MEM_SEL   = 8'h02
) (
    input  logic [IW-1:0] idx,
    input  logic [7:0]    data,
    input  logic [7:0]    vendor_code,
    output logic          sig_bad,
    output logic          des_hit,
    output logic          mark_hit,
    output logic          rsv_bad,
    output logic [3:0]    len_sel,
    output logic          dir_sel
);

    logic [3:0]    sig_lane_bad;
    logic          in_cb;
    logic [IW-1:0] cb_off;
    logic [7:0]    rsv_expect;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign sig_lane_bad[g] = (idx == IW'(CBW_SIG_BASE + g)) &&
                                 (data != SIGNATURE[8*g +: 8]);
        assign len_sel[g]      = (idx == IW'(CBW_LEN_BASE + g));
    end

    assign sig_bad  = |sig_lane_bad;
    assign dir_sel  = (idx == IW'(CBW_FLAG_IDX));
    assign des_hit  = (idx == IW'(CB_OFFSET)) && (data == vendor_code);
    assign mark_hit = (idx == IW'(CB_OFFSET + CB_MARK_OFF)) && (data == MARKER);

    assign in_cb      = (idx >= IW'(CB_OFFSET)) && (idx < IW'(CBW_BYTES));
    assign cb_off     = idx - IW'(CB_OFFSET);
    assign rsv_expect = (cb_off == IW'(CB_MSEL_OFF)) ? MEM_SEL : 8'h00;
    assign rsv_bad    = in_cb && (cb_off >= IW'(CB_RSV_FROM)) && (data != rsv_expect);

endmodule

// File: rtl/cbw_field_accum.sv
module cbw_field_accum
    import cbw_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       first,
    input  logic       capture,
    input  logic [7:0] data,
    input  logic       sig_bad,
    input  logic       des_hit,
    input  logic       mark_hit,
    input  logic       rsv_bad,
    input  logic [3:0] len_sel,
    input  logic       dir_sel,
    output cbw_acc_t   acc_next
);

    cbw_acc_t acc_q;

    always_comb begin
        acc_next = first ? '0 : acc_q;
        if (capture) begin
            acc_next.sig_bad  = acc_next.sig_bad  | sig_bad;
            acc_next.des_hit  = acc_next.des_hit  | des_hit;
            acc_next.mark_hit = acc_next.mark_hit | mark_hit;
            acc_next.rsv_bad  = acc_next.rsv_bad  | rsv_bad;
            for (int k = 0; k < 4; k++) begin
                if (len_sel[k]) acc_next.len[8*k +: 8] = data;
            end
            if (dir_sel) acc_next.dir = data[7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_next;
    end

endmodule

// File: rtl/cbw_cfg_decoder.sv
module cbw_cfg_decoder
    import cbw_cfg_pkg::*;
#(
    parameter int          CBW_BYTES = 31,
    parameter int          CB_OFFSET = 15,
    parameter int          MAX_XFER  = 255,
    parameter logic [31:0] SIGNATURE = 32'h4342_5355,
    parameter logic [7:0]  MARKER    = 8'h26,
    parameter logic [7:0]  MEM_SEL   = 8'h02
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic [7:0]  vendor_code,
    output logic        dec_valid,
    output logic        dec_is_cfg,
    output logic        dec_dir,
    output logic [31:0] dec_len,
    output logic        dec_err
);

    localparam int IW = $clog2(CBW_BYTES);

    logic [IW-1:0] byte_idx;
    logic          first, capture, fin, fin_len_err;
    logic          b_sig_bad, b_des_hit, b_mark_hit, b_rsv_bad, b_dir_sel;
    logic [3:0]    b_len_sel;
    cbw_acc_t      acc_next;
    logic          is_cfg_n, oversize_n, err_n;

    cbw_frame_fsm #(.CBW_BYTES(CBW_BYTES), .IW(IW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .byte_idx    (byte_idx),
        .first       (first),
        .capture     (capture),
        .fin         (fin),
        .fin_len_err (fin_len_err)
    );

    cbw_byte_check #(
        .CBW_BYTES (CBW_BYTES),
        .CB_OFFSET (CB_OFFSET),
        .IW        (IW),
        .SIGNATURE (SIGNATURE),
        .MARKER    (MARKER),
        .MEM_SEL   (MEM_SEL)
    ) u_check (
        .idx         (byte_idx),
        .data        (in_data),
        .vendor_code (vendor_code),
        .sig_bad     (b_sig_bad),
        .des_hit     (b_des_hit),
        .mark_hit    (b_mark_hit),
        .rsv_bad     (b_rsv_bad),
        .len_sel     (b_len_sel),
        .dir_sel     (b_dir_sel)
    );

    cbw_field_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .first    (first),
        .capture  (capture),
        .data     (in_data),
        .sig_bad  (b_sig_bad),
        .des_hit  (b_des_hit),
        .mark_hit (b_mark_hit),
        .rsv_bad  (b_rsv_bad),
        .len_sel  (b_len_sel),
        .dir_sel  (b_dir_sel),
        .acc_next (acc_next)
    );

    assign is_cfg_n   = acc_next.des_hit & acc_next.mark_hit;
    assign oversize_n = (acc_next.len > 32'(MAX_XFER));
    assign err_n      = fin_len_err | acc_next.sig_bad |
                        (is_cfg_n & (acc_next.rsv_bad | oversize_n));

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_is_cfg <= 1'b0;
            dec_dir    <= 1'b0;
            dec_len    <= '0;
            dec_err    <= 1'b0;
        end else begin
            dec_valid <= fin;
            if (fin) begin
                dec_is_cfg <= is_cfg_n;
                dec_dir    <= acc_next.dir;
                dec_len    <= acc_next.len;
                dec_err    <= err_n;
            end
        end
    end

endmodule

// File: rtl/cbw_cfg_decoder_chk.sv
module cbw_cfg_decoder_chk #(
    parameter int MAX_XFER = 255
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_last,
    input logic        dec_valid,
    input logic        dec_is_cfg,
    input logic        dec_dir,
    input logic [31:0] dec_len,
    input logic        dec_err
);

    // R2
    report_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> dec_valid);

    // R2
    no_spurious_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid && in_last));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> ($stable(dec_len) && $stable(dec_dir) &&
                                    $stable(dec_is_cfg) && $stable(dec_err)));

    // R8
    oversize_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_cfg && (dec_len > 32'(MAX_XFER))) |-> dec_err);

endmodule

bind cbw_cfg_decoder cbw_cfg_decoder_chk #(.MAX_XFER(MAX_XFER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .dec_valid  (dec_valid),
    .dec_is_cfg (dec_is_cfg),
    .dec_dir    (dec_dir),
    .dec_len    (dec_len),
    .dec_err    (dec_err)
);

// File: tb/cbw_cfg_decoder_tb.sv
module cbw_cfg_decoder_tb;

    localparam logic [31:0] SIG_OK = 32'h4342_5355;
    localparam logic [7:0]  VC     = 8'hC7;

    typedef struct packed {
        logic [31:0] sig;
        logic [7:0]  des;
        logic [7:0]  mark;
        logic [7:0]  msel;
        logic [5:0]  bad_pos;
        logic [31:0] len;
        logic        dir;
        logic [5:0]  nbytes;
        logic        gaps;
        logic        exp_cfg;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd64,        1'b0, 6'd31, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 good load
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd255,       1'b1, 6'd31, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 R8 read at limit
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd256,       1'b0, 6'd31, 1'b0, 1'b1, 1'b1, 4'd8},  // R8
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'h0100_0010, 1'b1, 6'd31, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 top byte
        '{32'h4342_5356, VC,  8'h26, 8'h02, 6'd0,  32'd8,         1'b0, 6'd31, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
        '{SIG_OK,      8'h28, 8'h26, 8'h02, 6'd0,  32'd8,         1'b0, 6'd31, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 other designator
        '{SIG_OK,      VC,    8'h25, 8'h02, 6'd0,  32'd8,         1'b0, 6'd31, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 bad marker
        '{SIG_OK,      VC,    8'h26, 8'h01, 6'd0,  32'd8,         1'b0, 6'd31, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 memory select
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd17, 32'd8,         1'b0, 6'd31, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 byte 17
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd19, 32'd8,         1'b1, 6'd31, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 start address
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd30, 32'd8,         1'b0, 6'd31, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 last byte
        '{SIG_OK,      8'h11, 8'h26, 8'h00, 6'd20, 32'd1000,      1'b0, 6'd31, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 fields ignored
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd8,         1'b0, 6'd20, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 short
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd77,        1'b1, 6'd33, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 long
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'd8,         1'b0, 6'd10, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 very short
        '{32'h0042_5355, 8'h11, 8'h26, 8'h02, 6'd0, 32'd8,        1'b0, 6'd31, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 non-config
        '{SIG_OK,      VC,    8'h26, 8'h02, 6'd0,  32'h0000_00A5, 1'b1, 6'd31, 1'b1, 1'b1, 1'b0, 4'd10}  // R10 gaps
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic [7:0]  vendor_code;
    logic        dec_valid, dec_is_cfg, dec_dir, dec_err;
    logic [31:0] dec_len;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [7:0] fb [0:39];

    always #2 clk = ~clk;

    cbw_cfg_decoder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .vendor_code (vendor_code),
        .dec_valid   (dec_valid),
        .dec_is_cfg  (dec_is_cfg),
        .dec_dir     (dec_dir),
        .dec_len     (dec_len),
        .dec_err     (dec_err)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s R%0d actual=%0h expected=%0h", what, req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic build(input vec_t v);
        for (int i = 0; i < 40; i++) fb[i] = (i > 30) ? 8'hAA : 8'h00;
        for (int i = 0; i < 4; i++) begin
            fb[i]     = v.sig[8*i +: 8];
            fb[4 + i] = 8'h30 + 8'(i);
            fb[8 + i] = v.len[8*i +: 8];
        end
        fb[12] = {v.dir, 7'b0};
        fb[14] = 8'd16;
        fb[15] = v.des;
        fb[16] = v.mark;
        fb[18] = v.msel;
        if (v.bad_pos != 0) fb[v.bad_pos] = 8'hFF;
    endtask

    task automatic push(input logic [7:0] d, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send(input int nb, input bit gaps);
        for (int i = 0; i < nb; i++) begin
            push(fb[i], i == nb - 1);
            if (gaps && (i % 3 == 1) && (i != nb - 1)) idle();
        end
        idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        vendor_code = VC;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("reset valid", 1, 32'(dec_valid), 0);
        chk("reset cfg",   1, 32'(dec_is_cfg), 0);
        chk("reset dir",   1, 32'(dec_dir), 0);
        chk("reset len",   1, dec_len, 0);
        chk("reset err",   1, 32'(dec_err), 0);

        for (int v = 0; v < NV; v++) begin
            build(VECS[v]);
            send(int'(VECS[v].nbytes), VECS[v].gaps);
            chk($sformatf("vec%0d valid", v), int'(VECS[v].req), 32'(dec_valid), 1);
            chk($sformatf("vec%0d cfg", v),   int'(VECS[v].req), 32'(dec_is_cfg), 32'(VECS[v].exp_cfg));
            chk($sformatf("vec%0d err", v),   int'(VECS[v].req), 32'(dec_err), 32'(VECS[v].exp_err));
            if (VECS[v].nbytes >= 13) begin
                // R3 length and direction
                chk($sformatf("vec%0d len", v), 3, dec_len, VECS[v].len);
                chk($sformatf("vec%0d dir", v), 3, 32'(dec_dir), 32'(VECS[v].dir));
            end
            idle();
            // R2 pulse ends, result held
            chk($sformatf("vec%0d pulse end", v), 2, 32'(dec_valid), 0);
            chk($sformatf("vec%0d held err", v),  2, 32'(dec_err), 32'(VECS[v].exp_err));
        end

        // R6 single-byte frame
        push(8'h55, 1'b1);
        idle();
        chk("one-byte valid", 6, 32'(dec_valid), 1);
        chk("one-byte err",   6, 32'(dec_err), 1);
        chk("one-byte cfg",   6, 32'(dec_is_cfg), 0);

        // R10 back-to-back frames: read at limit, then bad marker
        build(VECS[1]);
        for (int i = 0; i < 31; i++) push(fb[i], i == 30);
        build(VECS[6]);
        push(fb[0], 1'b0);
        chk("b2b first valid", 10, 32'(dec_valid), 1);
        chk("b2b first cfg",   10, 32'(dec_is_cfg), 1);
        chk("b2b first err",   10, 32'(dec_err), 0);
        chk("b2b first len",   10, dec_len, 32'd255);
        for (int i = 1; i < 31; i++) push(fb[i], i == 30);
        idle();
        chk("b2b second valid", 10, 32'(dec_valid), 1);
        chk("b2b second cfg",   10, 32'(dec_is_cfg), 0);
        chk("b2b second err",   10, 32'(dec_err), 0);

        // R1 reset in mid-frame, then a clean frame
        build(VECS[1]);
        for (int i = 0; i < 10; i++) push(fb[i], 1'b0);
        do_reset();
        @(negedge clk);
        chk("mid reset valid", 1, 32'(dec_valid), 0);
        chk("mid reset len",   1, dec_len, 0);
        build(VECS[0]);
        send(31, 1'b0);
        chk("post reset valid", 1, 32'(dec_valid), 1);
        chk("post reset cfg",   1, 32'(dec_is_cfg), 1);
        chk("post reset err",   1, 32'(dec_err), 0);
        chk("post reset len",   1, dec_len, 32'd64);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule